// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block produces an output clock from its input clock by counting input cycles. The high time and the low time are programmed separately, each as a count stored minus one. The output is therefore not tied to a 50% duty cycle. A synchronous write port holds the configuration. A SYNC input realigns the divider to a chosen start level, and a phase offset delays the first transition after SYNC. A SYNC-ignore mode lets the divider keep running through a SYNC pulse. A static mode, legal only while SYNC is ignored, parks the output at a fixed level.

The output can come from three places. It can be the divided clock. It can be the undivided input clock (bypass). It can be one of two external sources chosen by a direct-route field. A power-down bit freezes the counter and holds the divided output where it is.

All divider state is clocked by the input clock. Configuration writes take effect at that clock edge. A change to either count is picked up only when the output next changes level.

Top module: `clkdiv_top`

## Requirements
- R1: A low count N (field `wrData[3:0]` at address 0) holds the divided output low for exactly N+1 input cycles per period, for every N from 0 to 15.
- R2: A high count N (field `wrData[7:4]` at address 0) holds the divided output high for exactly N+1 input cycles per period, for every N from 0 to 15.
- R3: After reset all fields are 0 and the output is low. The divider then toggles on every input edge: 1, 0, 1, 0 on the first four edges after reset is released.
- R4: With bypass set (address 2, bit 0), `clkOut` equals the input clock: high while `clk` is high and low while it is low. The counter is frozen while bypass is set.
- R5: With SYNC-ignore clear, an input cycle with `syncIn` high loads the start level (address 1, bit 4; 1 = high) and restarts the counter. With offset 0 and the start level held for count N, the first transition comes on the (N+1)th edge after `syncIn` is sampled low.
- R6: With SYNC-ignore set (address 1, bit 5), `syncIn` has no effect on the output.
- R7: With force-enable (address 1, bit 6) and SYNC-ignore both set, the output is held at the force level (address 1, bit 7). With SYNC-ignore clear, force-enable is ignored.
- R8: A phase offset P (address 1, bits 3:0) holds the start level for P further input cycles after SYNC is released before counting begins.
- R9: With direct-route set (address 2, bit 1), source code 10 (address 2, bits 3:2) drives `clkOut` from `hsSrc`, code 00 drives it from `refSrc`, and codes 01 and 11 keep the divided output.
- R10: A count written mid-phase does not shorten the phase in progress. The new length applies from the next level change. A write on the same edge as a level change applies one change later.
- R11: With power-down set (address 2, bit 4), the divided output and the counter hold their values, and SYNC is ignored.
- R12: Writes with `wrEn` high at an address other than 0 to 2 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | 2 | Configuration word select |
| wrData | input | 8 | Configuration write data |
| syncIn | input | 1 | Realign request, active high |
| hsSrc | input | 1 | High-speed source for the direct route |
| refSrc | input | 1 | Reference source for the direct route |
| clkOut | output | 1 | Selected output clock |

## Verification
Two things can land on the same edge: a count write and a level change of the divided output. When they coincide, the old count still sets the new phase, and the written value takes over one level change later. The bench provokes this by writing alternating count values on a run of consecutive cycles, so some writes fall exactly on a transition. A behavioural model compares the output on every edge. SYNC arriving together with static mode or power-down is also provoked, and the model gives power-down, then static mode, then SYNC, the higher priority.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int CNT_W  = 4;
  parameter int ADDR_W = 2;
  parameter int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_LEN = 'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 'd1;
  localparam logic [ADDR_W-1:0] ADDR_OUT = 'd2;

  localparam logic [1:0] SRC_HS  = 2'b10;
  localparam logic [1:0] SRC_REF = 2'b00;

  typedef struct packed {
    logic [CNT_W-1:0] lowLen;
    logic [CNT_W-1:0] highLen;
    logic [CNT_W-1:0] phaseOff;
    logic             startHigh;
    logic             noSync;
    logic             forceEn;
    logic             forceLvl;
    logic             bypass;
    logic             directEn;
    logic [1:0]       srcSel;
    logic             powerDown;
  } divCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;       // freeze counter and output
    logic preset;     // load a level and restart counting
    logic presetVal;  // level to load on preset
  } divStrobe_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              syncIn,
  output divCfg_t           cfg,
  output divStrobe_t        strobe,
  output logic              offActive
);
  localparam int OFF_CMP_W = CNT_W + 1;

  logic [CNT_W-1:0] offCnt;
  logic             frozen;
  logic             staticMode;
  logic             syncHit;
  logic             offDone;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_LEN: begin
          cfg.lowLen  <= wrData[CNT_W-1:0];
          cfg.highLen <= wrData[2*CNT_W-1:CNT_W];
        end
        ADDR_CTL: begin
          cfg.phaseOff  <= wrData[CNT_W-1:0];
          cfg.startHigh <= wrData[4];
          cfg.noSync    <= wrData[5];
          cfg.forceEn   <= wrData[6];
          cfg.forceLvl  <= wrData[7];
        end
        ADDR_OUT: begin
          cfg.bypass    <= wrData[0];
          cfg.directEn  <= wrData[1];
          cfg.srcSel    <= wrData[3:2];
          cfg.powerDown <= wrData[4];
        end
        default: ;
      endcase
    end
  end

  assign frozen     = cfg.powerDown | cfg.bypass;
  assign staticMode = cfg.forceEn & cfg.noSync;
  assign syncHit    = syncIn & ~cfg.noSync;
  assign offDone    = ({1'b0, offCnt} + OFF_CMP_W'(1)) >= {1'b0, cfg.phaseOff};

  // priority: freeze, static, sync, offset wait, count
  always_comb begin
    strobe = '0;
    if (frozen) begin
      strobe.hold = 1'b1;
    end else if (staticMode) begin
      strobe.preset    = 1'b1;
      strobe.presetVal = cfg.forceLvl;
    end else if (syncHit) begin
      strobe.preset    = 1'b1;
      strobe.presetVal = cfg.startHigh;
    end else if (offActive) begin
      strobe.hold = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offActive <= 1'b0;
      offCnt    <= '0;
    end else if (frozen) begin
      offActive <= offActive;
    end else if (staticMode) begin
      offActive <= 1'b0;
      offCnt    <= '0;
    end else if (syncHit) begin
      offActive <= (cfg.phaseOff != '0);
      offCnt    <= '0;
    end else if (offActive) begin
      if (offDone) begin
        offActive <= 1'b0;
        offCnt    <= '0;
      end else begin
        offCnt <= offCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic [CNT_W-1:0] lowLen,
  input  logic [CNT_W-1:0] highLen,
  input  logic             bypass,
  input  logic             directEn,
  input  logic [1:0]       srcSel,
  input  logic             hsSrc,
  input  logic             refSrc,
  output logic             divOut,
  output logic             clkOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divOut <= 1'b0;
      cnt    <= '0;
      curLen <= '0;
    end else if (strobe.preset) begin
      divOut <= strobe.presetVal;
      cnt    <= '0;
      curLen <= strobe.presetVal ? highLen : lowLen;
    end else if (!strobe.hold) begin
      if (cnt == curLen) begin
        divOut <= ~divOut;
        cnt    <= '0;
        curLen <= divOut ? lowLen : highLen;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (directEn && srcSel == SRC_HS)       clkOut = hsSrc;
    else if (directEn && srcSel == SRC_REF) clkOut = refSrc;
    else if (!directEn && bypass)           clkOut = clk;
    else                                    clkOut = divOut;
  end
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              syncIn,
  input  logic              hsSrc,
  input  logic              refSrc,
  output logic              clkOut
);
  divCfg_t    cfg;
  divStrobe_t strobe;
  logic       offActive;
  logic       divOut;

  clkdiv_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .syncIn    (syncIn),
    .cfg       (cfg),
    .strobe    (strobe),
    .offActive (offActive)
  );

  clkdiv_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lowLen   (cfg.lowLen),
    .highLen  (cfg.highLen),
    .bypass   (cfg.bypass),
    .directEn (cfg.directEn),
    .srcSel   (cfg.srcSel),
    .hsSrc    (hsSrc),
    .refSrc   (refSrc),
    .divOut   (divOut),
    .clkOut   (clkOut)
  );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
  import clkdiv_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input divCfg_t cfg,
  input logic    syncIn,
  input logic    offActive,
  input logic    divOut
);
  logic running;
  assign running = !cfg.powerDown && !cfg.bypass;

  a_r11_pd_freeze: assert property (@(posedge clk) disable iff (!rstN)
    cfg.powerDown |=> divOut == $past(divOut));

  a_r4_bypass_freeze: assert property (@(posedge clk) disable iff (!rstN)
    cfg.bypass |=> divOut == $past(divOut));

  a_r7_static_level: assert property (@(posedge clk) disable iff (!rstN)
    (running && cfg.forceEn && cfg.noSync) |=> divOut == $past(cfg.forceLvl));

  a_r5_sync_start: assert property (@(posedge clk) disable iff (!rstN)
    (running && !cfg.noSync && syncIn) |=> divOut == $past(cfg.startHigh));

  a_r8_offset_hold: assert property (@(posedge clk) disable iff (!rstN)
    (running && !(cfg.forceEn && cfg.noSync) && !(syncIn && !cfg.noSync) && offActive)
      |=> $stable(divOut));
endmodule

bind clkdiv_top clkdiv_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfg       (cfg),
  .syncIn    (syncIn),
  .offActive (offActive),
  .divOut    (divOut)
);

// File: tb/tb_clkdiv_top.sv
`timescale 1ns/1ps
module tb_clkdiv_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       syncIn = 1'b0;
  logic       hsSrc = 1'b0;
  logic       refSrc = 1'b0;
  logic       clkOut;

  int    checks = 0;
  int    errors = 0;
  bit    chkEn = 1'b0;
  bit    finished = 1'b0;
  string curReq = "R3";

  always #2.5 clk = ~clk;

  clkdiv_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncIn(syncIn), .hsSrc(hsSrc), .refSrc(refSrc), .clkOut(clkOut)
  );

  // behavioural reference model
  int mLow = 0, mHigh = 0, mOff = 0, mSrc = 0;
  bit mStart = 0, mNoSync = 0, mForceEn = 0, mForceLvl = 0;
  bit mBypass = 0, mDirect = 0, mPd = 0;
  bit mDiv = 0, mWait = 0;
  int mRun = 0, mLen = 0, mWaited = 0;

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clkOut=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mLow = 0; mHigh = 0; mOff = 0; mSrc = 0; mStart = 0; mNoSync = 0;
      mForceEn = 0; mForceLvl = 0; mBypass = 0; mDirect = 0; mPd = 0;
      mDiv = 0; mWait = 0; mRun = 0; mLen = 0; mWaited = 0;
    end else begin
      if (mPd || mBypass) begin
        // frozen
      end else if (mForceEn && mNoSync) begin
        mDiv = mForceLvl; mRun = 0; mLen = mForceLvl ? mHigh : mLow; mWait = 0; mWaited = 0;
      end else if (syncIn && !mNoSync) begin
        mDiv = mStart; mRun = 0; mLen = mStart ? mHigh : mLow;
        mWait = (mOff != 0); mWaited = 0;
      end else if (mWait) begin
        mWaited++;
        if (mWaited >= mOff) begin mWait = 0; mWaited = 0; end
      end else if (mRun == mLen) begin
        mLen = mDiv ? mLow : mHigh; mDiv = !mDiv; mRun = 0;
      end else begin
        mRun++;
      end
      if (wrEn) begin
        if (wrAddr == 0) begin mLow = wrData[3:0]; mHigh = wrData[7:4]; end
        else if (wrAddr == 1) begin
          mOff = wrData[3:0]; mStart = wrData[4]; mNoSync = wrData[5];
          mForceEn = wrData[6]; mForceLvl = wrData[7];
        end else if (wrAddr == 2) begin
          mBypass = wrData[0]; mDirect = wrData[1]; mSrc = wrData[3:2]; mPd = wrData[4];
        end
      end
    end
    #1;
    if (rstN && chkEn) begin
      bit exp;
      if (mDirect && mSrc == 2) exp = hsSrc;
      else if (mDirect && mSrc == 0) exp = refSrc;
      else if (!mDirect && mBypass) exp = 1'b1;
      else exp = mDiv;
      check(clkOut, exp, curReq);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulseSync(input int n);
    @(negedge clk); syncIn = 1'b1;
    repeat (n) @(negedge clk);
    syncIn = 1'b0;
  endtask

  // measure one full high run and one full low run (R1, R2)
  task automatic measure(input int hi, input int lo);
    bit q[$];
    int runs[$];
    bit vals[$];
    int n;
    int gotHi, gotLo;
    wr(2'd0, 8'((hi << 4) | lo));
    pulseSync(1);
    n = 2 * (hi + lo + 2) + 6;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; q.push_back(clkOut);
    end
    runs.push_back(1); vals.push_back(q[0]);
    for (int i = 1; i < q.size(); i++) begin
      if (q[i] == vals[vals.size()-1]) runs[runs.size()-1]++;
      else begin runs.push_back(1); vals.push_back(q[i]); end
    end
    gotHi = -1; gotLo = -1;
    for (int i = 1; i < runs.size() - 1; i++) begin
      if (vals[i] && gotHi < 0) gotHi = runs[i];
      if (!vals[i] && gotLo < 0) gotLo = runs[i];
    end
    checks++;
    if (gotHi != hi + 1) begin
      errors++;
      $display("FAIL R2: high run=%0d expected=%0d (hi=%0d lo=%0d)", gotHi, hi + 1, hi, lo);
    end
    checks++;
    if (gotLo != lo + 1) begin
      errors++;
      $display("FAIL R1: low run=%0d expected=%0d (hi=%0d lo=%0d)", gotLo, lo + 1, hi, lo);
    end
  endtask

  // count edges from sync release to first change (R5, R8)
  task automatic firstEdge(input int off, input int len, input bit startLvl, input string req);
    int k;
    wr(2'd1, 8'((startLvl << 4) | off));
    wr(2'd0, 8'((len << 4) | len));
    pulseSync(2);
    k = 0;
    do begin
      @(posedge clk); #1; k++;
    end while (clkOut == startLvl && k < 60);
    checks++;
    if (k != off + len + 1) begin
      errors++;
      $display("FAIL %s: first edge at %0d expected=%0d", req, k, off + len + 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3: reset state
    #12;
    check(clkOut, 1'b0, "R3");
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; check(clkOut, (i % 2 == 0), "R3");
    end
    chkEn = 1'b1;

    // R1, R2: every count pair
    curReq = "R1";
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++)
        measure(h, l);

    // R5, R8: start level and offset
    curReq = "R5";
    firstEdge(0, 3, 1'b0, "R5");
    firstEdge(0, 5, 1'b1, "R5");
    curReq = "R8";
    firstEdge(4, 2, 1'b0, "R8");
    firstEdge(15, 1, 1'b1, "R8");
    wr(2'd1, 8'h00);

    // R10: writes on consecutive cycles, some on level changes
    curReq = "R10";
    wr(2'd0, 8'h33);
    pulseSync(1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); wrEn = 1'b1; wrAddr = 2'd0; wrData = (i % 2) ? 8'h71 : 8'h26;
    end
    @(negedge clk); wrEn = 1'b0;
    repeat (40) @(negedge clk);

    // R6: sync ignored
    curReq = "R6";
    wr(2'd0, 8'h42);
    wr(2'd1, 8'h30);
    repeat (3) @(negedge clk);
    pulseSync(3);
    repeat (20) @(negedge clk);

    // R7: static mode, then force ignored without nosync, then sync with static
    curReq = "R7";
    wr(2'd1, 8'hE0);
    pulseSync(2);
    repeat (10) @(negedge clk);
    wr(2'd1, 8'h60);
    repeat (10) @(negedge clk);
    wr(2'd1, 8'hC0);
    repeat (10) @(negedge clk);
    wr(2'd1, 8'h40);
    pulseSync(1);
    repeat (20) @(negedge clk);
    wr(2'd1, 8'h00);

    // R11: power-down freeze, sync arriving during power-down
    curReq = "R11";
    wr(2'd0, 8'h23);
    repeat (5) @(negedge clk);
    wr(2'd2, 8'h10);
    pulseSync(2);
    repeat (15) @(negedge clk);
    wr(2'd2, 8'h00);
    repeat (15) @(negedge clk);

    // R4: bypass follows the clock, low half checked at negedge
    curReq = "R4";
    wr(2'd2, 8'h01);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1; check(clkOut, 1'b0, "R4");
    end
    wr(2'd2, 8'h00);
    repeat (10) @(negedge clk);

    // R9: direct routing codes
    curReq = "R9";
    hsSrc = 1'b1; refSrc = 1'b0;
    wr(2'd2, 8'h0A);
    repeat (3) @(negedge clk);
    hsSrc = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h02);
    refSrc = 1'b1;
    repeat (3) @(negedge clk);
    refSrc = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h06);
    repeat (10) @(negedge clk);
    wr(2'd2, 8'h0E);
    repeat (10) @(negedge clk);
    wr(2'd2, 8'h00);

    // R12: unused address ignored
    curReq = "R12";
    wr(2'd3, 8'hFF);
    repeat (20) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule